// File: doc/BRIEF.md
# Acknowledge Polling Sequencer

After a write, a two-wire serial memory spends some time committing the data internally. During that time it stays off the bus and leaves its device select code unanswered. The datasheet write time is only an upper bound, and the real commit usually finishes sooner. This sequencer does not wait out the worst case. It probes the target repeatedly. Each probe is a start condition followed by the select byte of the instruction the host wants to issue next.

When a probe is acknowledged, the sequencer pulses `ready` and releases the byte-level bus master without issuing a stop. The host logic then continues the same instruction from its second byte, so the acknowledged select byte counts as part of that instruction.

When a probe is refused, the sequencer waits a programmable number of quiet cycles and probes again. A programmable probe limit ends a hopeless wait: the sequencer issues a stop and raises an error flag.

The bus side is a simplified byte-level master interface with three commands: start, send byte and stop. Exactly one request is held until the master pulses `bus_done`. For a send, `bus_done` carries the sampled acknowledge on `bus_ack`.

Top module: `acpoll_seq`

## Requirements
- R1: A `go` pulse while `busy` is low latches `sel_byte`, `probe_limit` and `gap_cycles`, and `busy` is high in the following cycle.
- R2: Each probe is a `bus_start_req` followed by a `bus_send_req` whose `bus_tx_data` equals the latched select byte. At most one request is high at a time, and each request is held until `bus_done`.
- R3: When a probe is acknowledged (`bus_ack`=1 with `bus_done` on a send), `ready` is high for exactly one cycle, `busy` is low in that cycle, and no stop request is issued.
- R4: When a probe is refused and probes remain, the next probe begins with a start request and no stop in between. Exactly `gap_cycles`+1 cycles with no bus request separate the refused send from that start.
- R5: After `probe_limit` refused probes, with a limit of 0 treated as 1, the sequencer issues one stop request. It then sets `err`, drops `busy`, and makes no further probe.
- R6: `err` stays high until the next accepted `go`, and is low in the cycle after that `go`.
- R7: A `go` pulse, or a change of `sel_byte`, `probe_limit` or `gap_cycles`, while `busy` is high has no effect on the running sequence.
- R8: After reset, all bus requests, `busy`, `ready` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a polling sequence (taken only while idle) |
| sel_byte | input | DATA_W | Device select byte of the next instruction |
| probe_limit | input | CNT_W | Maximum number of refused probes (0 acts as 1) |
| gap_cycles | input | GAP_W | Minimum quiet gap between a refused probe and the next one |
| ready | output | 1 | One-cycle pulse: target acknowledged, bus left open |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Sticky timeout flag, cleared by the next accepted go |
| bus_start_req | output | 1 | Request a start condition |
| bus_send_req | output | 1 | Request transmission of `bus_tx_data` |
| bus_stop_req | output | 1 | Request a stop condition |
| bus_tx_data | output | DATA_W | Byte to transmit |
| bus_done | input | 1 | Byte master finished the current request |
| bus_ack | input | 1 | Acknowledge sampled for a send, valid with `bus_done` |

## Verification
The probe-limit check and the refusal handling can land on the same `bus_done` edge. When the refusal that exhausts the limit arrives, the sequencer must choose a stop over a gap and a new start. The bench provokes this by setting the target's refusal count equal to the limit, one below it, and above it, including a limit of 0. In each case it judges the outcome from the number of starts, sends and stops, the presence of a `ready` pulse, and the final state of `err`. A second collision, a `go` arriving while a probe is in flight, is judged by watching that the transmitted byte, the probe count and the gap length follow the values latched at the accepted `go`.

// File: rtl/acpoll_pkg.sv
package acpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SEND,
    ST_GAP,
    ST_STOP
  } acp_state_t;

  // Effective limit: a programmed zero still allows one probe.
  function automatic int unsigned eff_limit(input int unsigned lim);
    return (lim == 0) ? 1 : lim;
  endfunction

  // True when the given number of refused probes uses up the limit.
  function automatic logic limit_hit(input int unsigned refused, input int unsigned lim);
    return refused >= eff_limit(lim);
  endfunction

endpackage

// File: rtl/acpoll_probe_cnt.sv
module acpoll_probe_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  // A refusal now would be the one that exhausts the limit.
  assign last = acpoll_pkg::limit_hit(int'(count) + 1, int'(limit));
endmodule

// File: rtl/acpoll_gap_tmr.sv
module acpoll_gap_tmr #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  input  logic             run,
  output logic             expired
);
  logic [GAP_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tmr <= '0;
    else if (load)              tmr <= gap;
    else if (run && tmr != '0)  tmr <= tmr - 1'b1;
  end

  assign expired = (tmr == '0);
endmodule

// File: rtl/acpoll_seq.sv
module acpoll_seq #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] sel_byte,
  input  logic [CNT_W-1:0]  probe_limit,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              ready,
  output logic              busy,
  output logic              err,
  output logic              bus_start_req,
  output logic              bus_send_req,
  output logic              bus_stop_req,
  output logic [DATA_W-1:0] bus_tx_data,
  input  logic              bus_done,
  input  logic              bus_ack
);
  import acpoll_pkg::*;

  acp_state_t        st, st_nx;
  logic [DATA_W-1:0] sel_q;
  logic [CNT_W-1:0]  lim_q;
  logic [GAP_W-1:0]  gap_q;
  logic [CNT_W-1:0]  refused;
  logic              last_try;
  logic              gap_over;
  logic              ready_q, err_q;

  // Named internal events, also used by the bound checker.
  logic go_take, probe_ack, probe_nack, give_up, stop_done;
  assign go_take    = (st == ST_IDLE) && go;
  assign probe_ack  = (st == ST_SEND) && bus_done && bus_ack;
  assign probe_nack = (st == ST_SEND) && bus_done && !bus_ack;
  assign give_up    = probe_nack && last_try;
  assign stop_done  = (st == ST_STOP) && bus_done;

  acpoll_probe_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go_take),
    .inc   (probe_nack),
    .limit (lim_q),
    .count (refused),
    .last  (last_try)
  );

  acpoll_gap_tmr #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (probe_nack),
    .gap     (gap_q),
    .run     (st == ST_GAP),
    .expired (gap_over)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (go) st_nx = ST_START;
      ST_START: if (bus_done) st_nx = ST_SEND;
      ST_SEND: begin
        if (probe_ack)    st_nx = ST_IDLE;
        else if (give_up) st_nx = ST_STOP;
        else if (bus_done) st_nx = ST_GAP;
      end
      ST_GAP:   if (gap_over) st_nx = ST_START;
      ST_STOP:  if (bus_done) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sel_q   <= '0;
      lim_q   <= '0;
      gap_q   <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st      <= st_nx;
      ready_q <= probe_ack;
      if (go_take) begin
        sel_q <= sel_byte;
        lim_q <= probe_limit;
        gap_q <= gap_cycles;
        err_q <= 1'b0;
      end else if (stop_done) begin
        err_q <= 1'b1;
      end
    end
  end

  assign ready         = ready_q;
  assign err           = err_q;
  assign busy          = (st != ST_IDLE);
  assign bus_start_req = (st == ST_START);
  assign bus_send_req  = (st == ST_SEND);
  assign bus_stop_req  = (st == ST_STOP);
  assign bus_tx_data   = sel_q;

  logic unused_ok;
  assign unused_ok = ^refused;
endmodule

// File: rtl/acpoll_seq_chk.sv
module acpoll_seq_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              ready,
  input logic              busy,
  input logic              err,
  input logic              bus_start_req,
  input logic              bus_send_req,
  input logic              bus_stop_req,
  input logic [DATA_W-1:0] bus_tx_data,
  input logic              bus_done,
  input logic              probe_ack,
  input logic              probe_nack,
  input logic              give_up,
  input logic [CNT_W-1:0]  lim_q,
  input logic [GAP_W-1:0]  gap_q
);
  logic             retry_pend;
  logic [GAP_W:0]   quiet;
  logic [CNT_W:0]   nack_seen;
  logic [CNT_W:0]   lim_eff;
  logic             any_req;

  assign any_req = bus_start_req | bus_send_req | bus_stop_req;
  assign lim_eff = (lim_q == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, lim_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_pend <= 1'b0;
      quiet      <= '0;
      nack_seen  <= '0;
    end else begin
      if (probe_nack && !give_up) begin
        retry_pend <= 1'b1;
        quiet      <= '0;
      end else if (bus_start_req) begin
        retry_pend <= 1'b0;
      end else if (retry_pend && !any_req && quiet != {(GAP_W+1){1'b1}}) begin
        quiet <= quiet + 1'b1;
      end
      if (go && !busy)    nack_seen <= '0;
      else if (probe_nack) nack_seen <= nack_seen + 1'b1;
    end
  end

  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_start_req, bus_send_req, bus_stop_req}));
  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_req && !bus_done |=> bus_start_req);
  p_send_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_send_req && !bus_done |=> bus_send_req);
  p_busy_after_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy |=> busy);
  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy && !bus_stop_req);
  p_ack_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_ack |=> !bus_stop_req);
  p_retry_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pend && bus_start_req |-> quiet == {1'b0, gap_q} + 1'b1);
  p_retry_no_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    probe_nack && !give_up |=> !bus_stop_req);
  p_timeout_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> bus_stop_req);
  p_probe_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen <= lim_eff);
  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && $past(bus_stop_req && bus_done));
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(go && !busy) |=> err);
  p_sel_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(bus_tx_data));
endmodule

bind acpoll_seq acpoll_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .go            (go),
  .ready         (ready),
  .busy          (busy),
  .err           (err),
  .bus_start_req (bus_start_req),
  .bus_send_req  (bus_send_req),
  .bus_stop_req  (bus_stop_req),
  .bus_tx_data   (bus_tx_data),
  .bus_done      (bus_done),
  .probe_ack     (probe_ack),
  .probe_nack    (probe_nack),
  .give_up       (give_up),
  .lim_q         (lim_q),
  .gap_q         (gap_q)
);

// File: tb/acpoll_seq_test.sv
`timescale 1ns/1ps
module acpoll_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [7:0] sel_byte = '0;
  logic [7:0] probe_limit = '0;
  logic [7:0] gap_cycles = '0;
  logic       ready, busy, err;
  logic       bus_start_req, bus_send_req, bus_stop_req;
  logic [7:0] bus_tx_data;
  logic       bus_done = 1'b0;
  logic       bus_ack = 1'b0;

  int total = 0;
  int bad = 0;

  // Shared between the target model, the monitor and the run task.
  int         nack_budget = 0;
  int         probe_idx = 0;
  int         n_start = 0, n_send = 0, n_stop = 0, n_ready = 0;
  int         gap_bad = 0, tx_bad = 0, rdy_wide = 0;
  logic [7:0] exp_sel = '0;
  int         exp_gap = 0;

  always #2 clk = ~clk;

  acpoll_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .sel_byte(sel_byte),
    .probe_limit(probe_limit), .gap_cycles(gap_cycles),
    .ready(ready), .busy(busy), .err(err),
    .bus_start_req(bus_start_req), .bus_send_req(bus_send_req),
    .bus_stop_req(bus_stop_req), .bus_tx_data(bus_tx_data),
    .bus_done(bus_done), .bus_ack(bus_ack)
  );

  function automatic int eff_lim(input int lim);
    if (lim <= 0) return 1;
    return lim;
  endfunction

  function automatic int exp_probes(input int nacks, input int lim);
    if (nacks < eff_lim(lim)) return nacks + 1;
    return eff_lim(lim);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Byte-level master plus busy target: answers after 0..2 wait cycles.
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (bus_done) begin
        bus_done = 1'b0;
        bus_ack  = 1'b0;
      end else if (bus_start_req || bus_send_req || bus_stop_req) begin
        if (lat == 0) begin
          bus_done = 1'b1;
          if (bus_send_req) begin
            bus_ack = (probe_idx >= nack_budget);
            probe_idx++;
            n_send++;
            if (bus_tx_data != exp_sel) tx_bad++;
          end
          lat = $urandom_range(0, 2);
        end else begin
          lat--;
        end
      end
    end
  end

  // Output monitor: request edges, quiet gaps, ready width.
  initial begin
    logic ps, pp, pr;
    int   quiet;
    ps = 0; pp = 0; pr = 0; quiet = 0;
    forever begin
      @(negedge clk);
      if (bus_start_req && !ps) begin
        if (n_start > 0 && quiet != exp_gap + 1) gap_bad++;
        n_start++;
      end
      if (bus_stop_req && !pp) n_stop++;
      if (ready) begin
        n_ready++;
        if (pr) rdy_wide++;
      end
      if (bus_start_req || bus_send_req || bus_stop_req) quiet = 0;
      else if (busy) quiet++;
      ps = bus_start_req; pp = bus_stop_req; pr = ready;
    end
  end

  task automatic run_one(input logic [7:0] sel, input int nacks, input int lim,
                         input int gap, input bit spam);
    int  ep, guard;
    bit  ok_path;
    ok_path = (nacks < eff_lim(lim));
    ep = exp_probes(nacks, lim);
    @(negedge clk);
    nack_budget = nacks; probe_idx = 0;
    n_start = 0; n_send = 0; n_stop = 0; n_ready = 0;
    gap_bad = 0; tx_bad = 0; rdy_wide = 0;
    exp_sel = sel; exp_gap = gap;
    sel_byte = sel; probe_limit = lim[7:0]; gap_cycles = gap[7:0];
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(busy == 1'b1, "R1 busy after go", int'(busy), 1);
    chk(err == 1'b0, "R6 err cleared by go", int'(err), 0);
    if (spam) begin
      // R7: disturbing values while running must change nothing.
      sel_byte = ~sel; probe_limit = 8'd1; gap_cycles = gap[7:0] + 8'd3;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    guard = 0;
    while (busy && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 3000, "R5 sequence terminates", guard, 0);
    repeat (2) @(negedge clk);
    chk(n_start == ep, "R4 start count", n_start, ep);
    chk(n_send == ep, "R2 send count", n_send, ep);
    chk(tx_bad == 0, "R2 R7 transmitted select byte", tx_bad, 0);
    chk(gap_bad == 0, "R4 quiet gap length", gap_bad, 0);
    chk(n_ready == (ok_path ? 1 : 0), "R3 ready pulses", n_ready, ok_path ? 1 : 0);
    chk(rdy_wide == 0, "R3 ready width", rdy_wide, 0);
    chk(n_stop == (ok_path ? 0 : 1), "R5 stop count", n_stop, ok_path ? 0 : 1);
    chk(err == !ok_path, "R5 err flag", int'(err), ok_path ? 0 : 1);
    if (!ok_path) begin
      repeat (5) @(negedge clk);
      chk(err == 1'b1, "R6 err sticky", int'(err), 1);
      chk(!bus_start_req && !busy, "R5 no probe after timeout", int'(busy), 0);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!bus_start_req && !bus_send_req && !bus_stop_req, "R8 requests idle in reset",
        int'(bus_start_req | bus_send_req | bus_stop_req), 0);
    chk(!busy && !ready && !err, "R8 status idle in reset", int'(busy | ready | err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !err, "R8 idle after reset", int'(busy | err), 0);

    // Directed corners.
    run_one(8'hA0, 0, 1, 0, 0);   // immediate acknowledge
    run_one(8'hA2, 3, 3, 2, 0);   // refusal count equals limit: timeout
    run_one(8'hA4, 2, 3, 1, 0);   // acknowledge on last allowed probe
    run_one(8'hA6, 1, 0, 0, 0);   // limit 0 acts as 1
    run_one(8'hA8, 0, 0, 4, 0);   // limit 0, immediate acknowledge
    run_one(8'h5A, 4, 6, 0, 1);   // disturbance while busy, zero gap
    run_one(8'h3C, 7, 4, 3, 1);   // timeout with disturbance

    for (int i = 0; i < 30; i++) begin
      run_one(8'($urandom()), $urandom_range(0, 7), $urandom_range(0, 6),
              $urandom_range(0, 5), 1'($urandom_range(0, 1)));
    end
    summary();
    $finish;
  end
endmodule